// File: doc/BRIEF.md
# Programmable Clock Output Divider Channel

This block forms one clock output of a frequency synthesiser. Its input is either a fast clock, which stands in for an oscillator output, or a slower reference clock. The selected clock passes through a cascade of two dividers. The first is a main divider with a 5-bit ratio that may be odd or even. The second is a power-of-two post divider. The overall division is the main ratio times the post ratio. The output waveform stays close to a 50% duty cycle for every ratio. Odd totals are balanced by a falling-edge copy of the phase register.

Two inputs can silence the output. The first is a master output enable. The second is an active-low power-down input, which also stops and clears the counters. Each has its own configuration bit that sets the silenced state. That state is either released to high impedance, shown as a low output-enable for an external tri-state driver, or actively driven low.

Changes to the divider settings are held back until the end of the current output period, so the output never shows a shortened cycle. When the output is enabled again, the divider starts from zero, and its first high phase has full length.

Top module: `clkdiv_channel`

## Requirements
- R1: When `src_sel` is 1 the divider counts reference clock cycles, so the output period is the total ratio times the reference period. When `src_sel` is 0 it counts fast clock cycles. The switch between sources is made without overlap of the two clocks.
- R2: For a `div_p` value from 2 to 31 with `post_sel` 0, the output period is `div_p` input clock periods.
- R3: A `div_p` value of 0 or 1 counts as a ratio of 1. With `post_sel` 0 the output then follows the input clock.
- R4: The `post_sel` encoding 0, 1, 2, 3 selects a post ratio of 1, 2, 4 or 8. The output period is the main ratio times this post ratio.
- R5: For every ratio, the output high time is within half an input period of half the output period.
- R6: While `oe_master` is 0 and `pd_n` is 1, `clk_out` stays 0. In this state `clk_oe` equals `oe_mode_low`, where 0 means high impedance and 1 means driven low.
- R7: While `pd_n` is 0, `clk_out` stays 0 and `clk_oe` equals `pd_mode_low`. This takes precedence over the master enable.
- R8: While the output is disabled, all counters are held at zero. On re-enable, the output rises at the next input rising edge, and its first high phase has full length.
- R9: A new `div_p` or `post_sel` value takes effect only at the end of the output period in progress. That period keeps its old length.
- R10: During reset, `clk_out` is 0 and `clk_oe` is 1.
- R11: While enabled and not powered down, `clk_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast input clock (oscillator stand-in) |
| ref_clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Active-low reset, synchronous to each clock |
| src_sel | input | 1 | 0 selects the fast clock, 1 selects the reference clock |
| div_p | input | 5 | Main divide ratio; 0 and 1 mean divide by one |
| post_sel | input | 2 | Post ratio select: 0 is /1, 1 is /2, 2 is /4, 3 is /8 |
| oe_master | input | 1 | Master output enable, active high |
| pd_n | input | 1 | Power-down, active low |
| oe_mode_low | input | 1 | Silenced state under master disable: 0 is high impedance, 1 is driven low |
| pd_mode_low | input | 1 | Silenced state under power-down: 0 is high impedance, 1 is driven low |
| clk_out | output | 1 | Divided clock output |
| clk_oe | output | 1 | Enable for the external tri-state output driver |

## Verification
The embedded assertions check on every cycle that only one source clock is enabled at a time. They also check that the main counter stays below the loaded ratio and that loaded settings change only at a period boundary. Further cycle-by-cycle checks are that disabling clears the counters, that a restart begins at count zero with the phase high, and that power-down forces the silenced levels. Output period, duty balance, and the settings carried through the source switch can only be seen over whole output periods, so the bench measures them for each scenario. The same holds for the delayed effect of a mid-period setting change and for the timing of the first pulse after re-enable.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared widths for the clock output divider channel.
// Assumes one main-ratio field and one post-ratio select field per channel.
package clkdiv_pkg;
    localparam int CH_P_W    = 5;   // main divide ratio field width
    localparam int CH_POST_W = 2;   // post ratio select width (ratio = 2**select)
endpackage

// File: rtl/clk_src_mux.sv
`timescale 1ns/1ps
// Module: clk_src_mux
// Glitch-free selection between two unrelated clocks. Each side holds an
// enable flop clocked on its own falling edge. A side may enable only after
// the other side has dropped its enable. Assumes sel_ref is stable for
// several cycles of both clocks around a change.
module clk_src_mux (
    input  logic fast_clk,
    input  logic ref_clk,
    input  logic rst_n,
    input  logic sel_ref,
    output logic mux_clk
);
    logic fast_en;
    logic ref_en;

    // Fast side enable: granted when selected and the reference side is idle.
    always_ff @(negedge fast_clk) begin
        if (!rst_n) fast_en <= 1'b1;
        else        fast_en <= !sel_ref && !ref_en;
    end

    // Reference side enable: granted when selected and the fast side is idle.
    always_ff @(negedge ref_clk) begin
        if (!rst_n) ref_en <= 1'b0;
        else        ref_en <= sel_ref && !fast_en;
    end

    assign mux_clk = (fast_clk & fast_en) | (ref_clk & ref_en);

    // R1: the two clock enables never overlap.
    a_r1_one_source: assert property (@(posedge fast_clk) disable iff (!rst_n)
        $onehot0({fast_en, ref_en}));
endmodule

// File: rtl/chan_divider.sv
`timescale 1ns/1ps
// Module: chan_divider
// A main counter (ratio P, odd or even) feeds a post counter (ratio
// 2**post_set). One phase register rises at each period boundary and falls
// at the half point. For odd totals, a falling-edge copy is ANDed in to
// balance the duty cycle. Settings load only at a period boundary or while
// idle. Assumes run_req is synchronous to div_clk.
module chan_divider #(
    parameter int P_W    = clkdiv_pkg::CH_P_W,
    parameter int POST_W = clkdiv_pkg::CH_POST_W
) (
    input  logic              div_clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [P_W-1:0]    p_set,
    input  logic [POST_W-1:0] post_set,
    output logic              div_out
);
    localparam int KC_W = (1 << POST_W) - 1;   // post counter width

    logic [P_W-1:0]    p_q, p_in, cnt_q, cnt_n;
    logic [POST_W-1:0] s_q;
    logic [KC_W-1:0]   post_q, post_n;
    logic [KC_W:0]     k_full;
    logic [P_W:0]      hi_main;
    logic              run_q, ph_r, ph_f, ph_n;
    logic              last_main, last_all, bypass, odd_tot;

    // Settings decode: ratios below two fold to one; post ratio is a power of two.
    always_comb begin
        p_in      = (p_set < P_W'(2)) ? P_W'(1) : p_set;
        k_full    = (KC_W+1)'(1) << s_q;
        hi_main   = ({1'b0, p_q} + (P_W+1)'(1)) >> 1;
        last_main = (cnt_q == p_q - P_W'(1));
        last_all  = last_main && ({1'b0, post_q} == k_full - (KC_W+1)'(1));
        bypass    = (p_q == P_W'(1)) && (s_q == '0);
        odd_tot   = p_q[0] && (s_q == '0);
    end

    // Next count and next phase of the cascaded counters.
    always_comb begin
        if (last_main) begin
            cnt_n  = '0;
            post_n = last_all ? '0 : post_q + KC_W'(1);
        end else begin
            cnt_n  = cnt_q + P_W'(1);
            post_n = post_q;
        end
        if (last_all)
            ph_n = 1'b1;
        else if (s_q == '0)
            ph_n = ({1'b0, cnt_n} == hi_main) ? 1'b0 : ph_r;
        else
            ph_n = (cnt_n == '0 && {1'b0, post_n} == (k_full >> 1)) ? 1'b0 : ph_r;
    end

    // Counter, phase and settings registers with idle clear and restart.
    always_ff @(posedge div_clk) begin
        if (!rst_n) begin
            run_q <= 1'b0; p_q <= P_W'(1); s_q <= '0;
            cnt_q <= '0;   post_q <= '0;   ph_r <= 1'b0;
        end else if (!run_req) begin
            run_q <= 1'b0; p_q <= p_in;    s_q <= post_set;
            cnt_q <= '0;   post_q <= '0;   ph_r <= 1'b0;
        end else if (!run_q) begin
            run_q <= 1'b1; p_q <= p_in;    s_q <= post_set;
            cnt_q <= '0;   post_q <= '0;   ph_r <= 1'b1;
        end else begin
            cnt_q <= cnt_n; post_q <= post_n; ph_r <= ph_n;
            if (last_all) begin
                p_q <= p_in;
                s_q <= post_set;
            end
        end
    end

    // Half-cycle delayed phase copy used to balance odd totals.
    always_ff @(negedge div_clk) begin
        if (!rst_n) ph_f <= 1'b0;
        else        ph_f <= ph_r;
    end

    assign div_out = bypass  ? (div_clk & run_q) :
                     odd_tot ? (ph_r & ph_f) : ph_r;

    // R2: the main counter stays below the loaded ratio.
    a_r2_cnt_in_range: assert property (@(posedge div_clk) disable iff (!rst_n)
        cnt_q < p_q);
    // R9: a running channel changes its ratio only after a period boundary.
    a_r9_cfg_at_wrap: assert property (@(posedge div_clk) disable iff (!rst_n)
        (run_q && $past(run_q) && (p_q != $past(p_q))) |-> $past(last_all));
    // R8: an idle request clears the counters and the phase.
    a_r8_idle_zero: assert property (@(posedge div_clk) disable iff (!rst_n)
        !run_req |=> (cnt_q == '0 && post_q == '0 && !ph_r));
    // R8: a restart begins at count zero with the phase high.
    a_r8_restart_high: assert property (@(posedge div_clk) disable iff (!rst_n)
        (run_q && !$past(run_q)) |-> (ph_r && cnt_q == '0));
endmodule

// File: rtl/out_gate.sv
`timescale 1ns/1ps
// Module: out_gate
// Output gating for the master enable and power-down. Power-down takes
// precedence. Each silencing source has its own mode bit: 1 drives low,
// 0 releases the tri-state driver. Assumes div_out is already low while idle.
module out_gate (
    input  logic div_clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic oe_master,
    input  logic pd_mode_low,
    input  logic oe_mode_low,
    input  logic div_out,
    output logic clk_out,
    output logic clk_oe
);
    // Driver enable chosen by the highest-priority silencing source.
    always_comb begin
        if (!pd_n)           clk_oe = pd_mode_low;
        else if (!oe_master) clk_oe = oe_mode_low;
        else                 clk_oe = 1'b1;
    end

    assign clk_out = pd_n & oe_master & div_out;

    // R7: power-down forces its silenced level.
    a_r7_pd_level: assert property (@(posedge div_clk) disable iff (!rst_n)
        !pd_n |-> (!clk_out && clk_oe == pd_mode_low));
    // R6: master disable forces its silenced level.
    a_r6_oe_level: assert property (@(posedge div_clk) disable iff (!rst_n)
        (pd_n && !oe_master) |-> (!clk_out && clk_oe == oe_mode_low));
endmodule

// File: rtl/clkdiv_channel.sv
`timescale 1ns/1ps
// Module: clkdiv_channel (top)
// One clock output channel: source mux, cascaded divider, output gating.
// Assumes the enable and power-down inputs change away from divider clock
// edges, and reset is held for several cycles of both clocks.
module clkdiv_channel #(
    parameter int P_W    = clkdiv_pkg::CH_P_W,
    parameter int POST_W = clkdiv_pkg::CH_POST_W
) (
    input  logic              fast_clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              src_sel,
    input  logic [P_W-1:0]    div_p,
    input  logic [POST_W-1:0] post_sel,
    input  logic              oe_master,
    input  logic              pd_n,
    input  logic              oe_mode_low,
    input  logic              pd_mode_low,
    output logic              clk_out,
    output logic              clk_oe
);
    logic div_clk;
    logic div_out;
    logic run_req;

    assign run_req = pd_n & oe_master;

    clk_src_mux u_mux (
        .fast_clk (fast_clk),
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .sel_ref  (src_sel),
        .mux_clk  (div_clk)
    );

    chan_divider #(.P_W(P_W), .POST_W(POST_W)) u_div (
        .div_clk  (div_clk),
        .rst_n    (rst_n),
        .run_req  (run_req),
        .p_set    (div_p),
        .post_set (post_sel),
        .div_out  (div_out)
    );

    out_gate u_gate (
        .div_clk     (div_clk),
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .oe_master   (oe_master),
        .pd_mode_low (pd_mode_low),
        .oe_mode_low (oe_mode_low),
        .div_out     (div_out),
        .clk_out     (clk_out),
        .clk_oe      (clk_oe)
    );
endmodule

// File: tb/clkdiv_channel_test.sv
`timescale 1ns/1ps
module clkdiv_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 24;
    localparam int WATCHDOG_CYC = 150000;

    logic fast_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, src_sel = 1'b0;
    logic [4:0] div_p = 5'd4;
    logic [1:0] post_sel = 2'd0;
    logic oe_master = 1'b1, pd_n = 1'b1, oe_mode_low = 1'b0, pd_mode_low = 1'b0;
    logic clk_out, clk_oe;
    int n_tests = 0, n_fail = 0, rise_cnt = 0;

    always #(CLK_PERIOD/2) fast_clk = ~fast_clk;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;
    always @(posedge clk_out) rise_cnt++;

    clkdiv_channel uut (
        .fast_clk(fast_clk), .ref_clk(ref_clk), .rst_n(rst_n), .src_sel(src_sel),
        .div_p(div_p), .post_sel(post_sel), .oe_master(oe_master), .pd_n(pd_n),
        .oe_mode_low(oe_mode_low), .pd_mode_low(pd_mode_low),
        .clk_out(clk_out), .clk_oe(clk_oe)
    );

    function automatic real rabs(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic check(input bit ok, input string req, input real act, input real exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
        end
    endtask

    // Inputs change just after a fast falling edge, clear of every clock edge.
    task automatic step(input int n);
        repeat (n) @(negedge fast_clk);
        #1;
    endtask

    // Load a setting, let it take effect, then measure one period and its high time.
    task automatic measure_cfg(input int p, input int s, input real tin, input string req);
        int n;
        real t1, tf, t2;
        n = ((p < 2) ? 1 : p) << s;
        div_p = 5'(p);
        post_sel = 2'(s);
        @(posedge clk_out);
        @(posedge clk_out);
        t1 = $realtime;
        @(negedge clk_out);
        tf = $realtime;
        @(posedge clk_out);
        t2 = $realtime;
        check(rabs((t2 - t1) - n * tin) < 0.01, req, t2 - t1, n * tin);
        check(rabs((tf - t1) - n * tin / 2.0) <= tin / 2.0 + 0.01, "R5 duty", tf - t1, n * tin / 2.0);
        step(1);
    endtask

    task automatic test_reset;
        step(2);
        check(clk_out == 1'b0, "R10 out in reset", real'(clk_out), 0.0);
        check(clk_oe == 1'b1, "R10 oe in reset", real'(clk_oe), 1.0);
    endtask

    task automatic test_main_sweep;
        step(4);
        check(clk_oe == 1'b1, "R11 oe running", real'(clk_oe), 1.0);
        measure_cfg(0, 0, CLK_PERIOD, "R3 p0 pass");
        measure_cfg(1, 0, CLK_PERIOD, "R3 p1 pass");
        for (int p = 2; p < 32; p++) measure_cfg(p, 0, CLK_PERIOD, "R2 main ratio");
    endtask

    task automatic test_post;
        int plist[5] = '{1, 2, 3, 7, 31};
        for (int s = 1; s < 4; s++)
            for (int i = 0; i < 5; i++) measure_cfg(plist[i], s, CLK_PERIOD, "R4 post ratio");
    endtask

    task automatic test_source;
        src_sel = 1'b1;
        step(10);
        measure_cfg(3, 1, REF_PERIOD, "R1 ref source");
        measure_cfg(5, 0, REF_PERIOD, "R1 ref odd");
        src_sel = 1'b0;
        step(10);
        measure_cfg(6, 0, CLK_PERIOD, "R1 back to fast");
    endtask

    task automatic test_master_oe;
        int rc;
        real t_en, t1, tf, t2;
        measure_cfg(4, 0, CLK_PERIOD, "R2 pre-disable");
        oe_master = 1'b0; oe_mode_low = 1'b0;
        step(3);
        rc = rise_cnt;
        check(clk_out == 1'b0, "R6 out low", real'(clk_out), 0.0);
        check(clk_oe == 1'b0, "R6 hi-z mode", real'(clk_oe), 0.0);
        oe_mode_low = 1'b1;
        step(30);
        check(clk_oe == 1'b1, "R6 drive-low mode", real'(clk_oe), 1.0);
        check(rise_cnt == rc, "R6 no edges", real'(rise_cnt - rc), 0.0);
        oe_master = 1'b1;
        t_en = $realtime;
        @(posedge clk_out);
        t1 = $realtime;
        @(negedge clk_out);
        tf = $realtime;
        @(posedge clk_out);
        t2 = $realtime;
        check((t1 - t_en) <= CLK_PERIOD, "R8 prompt restart", t1 - t_en, CLK_PERIOD);
        check(rabs((tf - t1) - 2.0 * CLK_PERIOD) < 0.01, "R8 full first high", tf - t1, 2.0 * CLK_PERIOD);
        check(rabs((t2 - t1) - 4.0 * CLK_PERIOD) < 0.01, "R8 first period", t2 - t1, 4.0 * CLK_PERIOD);
        step(1);
    endtask

    task automatic test_power_down;
        int rc;
        pd_n = 1'b0; pd_mode_low = 1'b0; oe_mode_low = 1'b1;
        step(3);
        rc = rise_cnt;
        check(clk_out == 1'b0, "R7 out low", real'(clk_out), 0.0);
        check(clk_oe == 1'b0, "R7 hi-z mode", real'(clk_oe), 0.0);
        pd_mode_low = 1'b1; oe_master = 1'b0; oe_mode_low = 1'b0;
        step(30);
        check(clk_oe == 1'b1, "R7 precedence drive-low", real'(clk_oe), 1.0);
        check(rise_cnt == rc, "R7 no edges", real'(rise_cnt - rc), 0.0);
        oe_master = 1'b1; pd_n = 1'b1;
        step(2);
        check(clk_oe == 1'b1, "R11 oe after wake", real'(clk_oe), 1.0);
        measure_cfg(5, 0, CLK_PERIOD, "R8 after power-down");
    endtask

    task automatic test_cfg_timing;
        real t1, t2, t3;
        measure_cfg(20, 0, CLK_PERIOD, "R2 p20");
        @(posedge clk_out);
        t1 = $realtime;
        step(3);
        div_p = 5'd4;
        @(posedge clk_out);
        t2 = $realtime;
        @(posedge clk_out);
        t3 = $realtime;
        check(rabs((t2 - t1) - 20.0 * CLK_PERIOD) < 0.01, "R9 old period kept", t2 - t1, 20.0 * CLK_PERIOD);
        check(rabs((t3 - t2) - 4.0 * CLK_PERIOD) < 0.01, "R9 new period", t3 - t2, 4.0 * CLK_PERIOD);
        step(1);
    endtask

    initial begin
        #(WATCHDOG_CYC * CLK_PERIOD);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(1);
        test_reset();
        step(8);
        rst_n = 1'b1;
        test_main_sweep();
        test_post();
        test_source();
        test_master_oe();
        test_power_down();
        test_cfg_timing();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule